// File: doc/BRIEF.md
# Paired-Instruction Completion Timer

This block tracks how long a dual-issued instruction pair holds the integer execution pipes. A pair is a primary instruction and an optional secondary one. When a pair is issued, the block takes the memory-operation class of each instruction and two hazard flags. From these it works out how many cycles the pair occupies. It keeps `ready_o` low for that many cycles. In the first cycle the pipes are free again, it raises a single-cycle `done_o`.

The pair occupancy depends on which instruction comes first. A primary that writes memory cannot overlap with a secondary that reads memory, but a primary that only reads memory can. Two further hazards affect the count. A cache-bank conflict between two plain operations serialises them. An address-generation stall on the secondary instruction stretches the pair. The issue logic upstream waits for `ready_o` before it sends the next pair.

Top module: `pair_occ_timer`

## Requirements
- R1: While `rst_ni` is low and in the first cycle after it is released, `ready_o` is 1 and `done_o` is 0.
- R2: Class encodings are 2'b00 register/move, 2'b01 read-modify, 2'b10 read-modify-write. 2'b11 behaves as 2'b00. With `sec_vld_i` low the occupancy is 1, 2, 3 or 1 cycles for primary class 00, 01, 10 or 11.
- R3: With a register/move primary and a valid secondary, the occupancy is 1, 2 or 3 for a secondary class of 00, 01 or 10.
- R4: With a read-modify primary, the occupancy is 2, 2 or 3 for a secondary class of 00, 01 or 10.
- R5: With a read-modify-write primary, the occupancy is 3, 4 or 5 for a secondary class of 00, 01 or 10.
- R6: `bank_conf_i` with a valid secondary raises a register/move + register/move pair to 2 cycles. It leaves every other class pair at its table value.
- R7: `agi_stall_i` with a valid secondary adds `AGI_PENALTY` cycles (default 1) to the occupancy, on top of any bank-conflict value.
- R8: With `sec_vld_i` low, `sec_cls_i`, `bank_conf_i` and `agi_stall_i` have no effect on the occupancy.
- R9: After an accepted issue (`issue_i` high while `ready_o` high), `ready_o` is low for exactly the occupancy's number of cycles.
- R10: `done_o` is high for exactly one cycle, and that cycle is the first one in which `ready_o` is high again.
- R11: `issue_i` asserted while `ready_o` is low is ignored and does not change the current pair's duration. With `ready_o` high and `issue_i` low, `ready_o` stays high.
- R12: An issue presented in the `done_o` cycle is accepted, so pairs can run back to back with no idle cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| issue_i | input | 1 | Pair issue request, taken when `ready_o` is high |
| pri_cls_i | input | 2 | Primary instruction operation class |
| sec_cls_i | input | 2 | Secondary instruction operation class |
| sec_vld_i | input | 1 | Secondary instruction present |
| bank_conf_i | input | 1 | The two memory operands hit the same cache bank |
| agi_stall_i | input | 1 | Secondary instruction has an address-generation stall |
| ready_o | output | 1 | Pipes free; a new pair may issue |
| done_o | output | 1 | Single-cycle pulse when the pair in flight completes |

## Verification
Completion of one pair and acceptance of the next can fall in the same cycle: `done_o` is high while `issue_i` is presented. The bench provokes this by issuing the next pair at the very sample point where it sees `done_o`, both in directed sequences and whenever the random stream chooses no idle gap. It judges the overlap by measuring the new pair's busy time against the independently computed occupancy. A lost or doubled cycle at the seam shows up as a wrong count or as a `done_o` that is missing or arrives early.

// File: rtl/pair_occ_pkg.sv
package pair_occ_pkg;

  typedef enum logic [1:0] {
    CLS_REG  = 2'b00,
    CLS_RM   = 2'b01,
    CLS_RMW  = 2'b10,
    CLS_RSVD = 2'b11
  } op_cls_e;

  // worst-case table value before stall penalty
  localparam int unsigned BASE_MAX = 5;

  function automatic int unsigned solo_cost(op_cls_e c);
    case (c)
      CLS_RM:  return 2;
      CLS_RMW: return 3;
      default: return 1;
    endcase
  endfunction

  function automatic op_cls_e fold_cls(logic [1:0] raw);
    return (raw == CLS_RSVD) ? CLS_REG : op_cls_e'(raw);
  endfunction

endpackage

// File: rtl/pair_occ_lookup.sv
module pair_occ_lookup
  import pair_occ_pkg::*;
#(
  parameter int unsigned AGI_PENALTY = 1,
  parameter int unsigned CNT_W       = 3
) (
  input  logic [1:0]       pri_cls_i,
  input  logic [1:0]       sec_cls_i,
  input  logic             sec_vld_i,
  input  logic             bank_conf_i,
  input  logic             agi_stall_i,
  output logic [CNT_W-1:0] occ_o
);

  op_cls_e     p_cls, s_cls;
  int unsigned cp, cs, occ;

  always_comb begin
    p_cls = fold_cls(pri_cls_i);
    s_cls = fold_cls(sec_cls_i);
    cp    = solo_cost(p_cls);
    cs    = solo_cost(s_cls);
    if (!sec_vld_i)
      occ = cp;
    else if (p_cls == CLS_RMW && s_cls != CLS_REG)
      occ = cp + cs - 1;                  // write-back blocks memory-reading partner
    else
      occ = (cp > cs) ? cp : cs;
    if (sec_vld_i && bank_conf_i && p_cls == CLS_REG && s_cls == CLS_REG)
      occ = 2;                            // same bank: serialised
    if (sec_vld_i && agi_stall_i)
      occ = occ + AGI_PENALTY;
    occ_o = CNT_W'(occ);
  end

endmodule

// File: rtl/pair_occ_counter.sv
module pair_occ_counter #(
  parameter int unsigned CNT_W   = 3,
  parameter int unsigned OCC_MAX = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] occ_i,
  output logic             ready_o,
  output logic             done_o
);

  logic [CNT_W-1:0] cnt_q;
  logic             done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= (cnt_q == CNT_W'(1));
      if (load_i)
        cnt_q <= occ_i;
      else if (cnt_q != '0)
        cnt_q <= cnt_q - CNT_W'(1);
    end
  end

  assign ready_o = (cnt_q == '0);
  assign done_o  = done_q;

  a_r9_load_blocks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> !ready_o);

  a_r9_occ_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |-> (occ_i != '0 && occ_i <= CNT_W'(OCC_MAX)));

  a_r10_done_when_free: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> ready_o);

  a_r10_done_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  a_r10_free_brings_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ready_o) |-> done_o);

endmodule

// File: rtl/pair_occ_timer.sv
module pair_occ_timer
  import pair_occ_pkg::*;
#(
  parameter int unsigned AGI_PENALTY = 1
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       issue_i,
  input  logic [1:0] pri_cls_i,
  input  logic [1:0] sec_cls_i,
  input  logic       sec_vld_i,
  input  logic       bank_conf_i,
  input  logic       agi_stall_i,
  output logic       ready_o,
  output logic       done_o
);

  localparam int unsigned OCC_MAX = BASE_MAX + AGI_PENALTY;
  localparam int unsigned CNT_W   = $clog2(OCC_MAX + 1);

  logic [CNT_W-1:0] occ;
  logic             accept;

  assign accept = issue_i & ready_o;

  pair_occ_lookup #(
    .AGI_PENALTY(AGI_PENALTY),
    .CNT_W      (CNT_W)
  ) u_lookup (
    .pri_cls_i  (pri_cls_i),
    .sec_cls_i  (sec_cls_i),
    .sec_vld_i  (sec_vld_i),
    .bank_conf_i(bank_conf_i),
    .agi_stall_i(agi_stall_i),
    .occ_o      (occ)
  );

  pair_occ_counter #(
    .CNT_W  (CNT_W),
    .OCC_MAX(OCC_MAX)
  ) u_counter (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (accept),
    .occ_i  (occ),
    .ready_o(ready_o),
    .done_o (done_o)
  );

  a_r11_idle_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ready_o && !issue_i) |=> ready_o);

  a_r12_back_to_back: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && issue_i) |=> !ready_o);

endmodule

// File: tb/pair_occ_timer_bench.sv
module pair_occ_timer_bench;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 150000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       issue = 1'b0;
  logic [1:0] pcls = 2'b00, scls = 2'b00;
  logic       svld = 1'b0, bank = 1'b0, agi = 1'b0;
  logic       ready, done;

  int n_chk = 0;
  int n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pair_occ_timer u_pair_occ_timer (
    .clk_i(clk), .rst_ni(rst_n), .issue_i(issue),
    .pri_cls_i(pcls), .sec_cls_i(scls), .sec_vld_i(svld),
    .bank_conf_i(bank), .agi_stall_i(agi),
    .ready_o(ready), .done_o(done)
  );

  function automatic int ref_occ(logic [1:0] p, logic [1:0] s, logic v, logic b, logic a);
    logic [1:0] pp, ss;
    int t;
    pp = (p == 2'b11) ? 2'b00 : p;
    ss = (s == 2'b11) ? 2'b00 : s;
    if (!v) return int'(pp) + 1;
    case ({pp, ss})
      4'b0000: t = 1; 4'b0001: t = 2; 4'b0010: t = 3;
      4'b0100: t = 2; 4'b0101: t = 2; 4'b0110: t = 3;
      4'b1000: t = 3; 4'b1001: t = 4; 4'b1010: t = 5;
      default: t = 99;
    endcase
    if (b && pp == 2'b00 && ss == 2'b00) t = 2;
    if (a) t = t + 1;
    return t;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Entered at a negedge with ready high; returns at the negedge where ready is back.
  task automatic run_pair(input logic [1:0] p, input logic [1:0] s, input logic v,
                          input logic b, input logic a, input bit junk, input string req);
    int exp, cnt;
    exp = ref_occ(p, s, v, b, a);
    pcls = p; scls = s; svld = v; bank = b; agi = a; issue = 1'b1;
    @(negedge clk);
    cnt = 0;
    while (!ready && cnt < 20) begin
      cnt++;
      issue = junk ? 1'($urandom_range(0, 1)) : 1'b0;  // R11: ignored while busy
      pcls = 2'($urandom_range(0, 3)); scls = 2'($urandom_range(0, 3));
      svld = 1'($urandom_range(0, 1)); agi = 1'($urandom_range(0, 1));
      @(negedge clk);
    end
    issue = 1'b0;
    chk(cnt == exp, req, cnt, exp);
    chk(done == 1'b1, "R10 done at free", int'(done), 1);
  endtask

  task automatic idle_check();
    @(negedge clk);
    chk(done == 1'b0, "R10 single pulse", int'(done), 0);
    chk(ready == 1'b1, "R11 idle ready", int'(ready), 1);
  endtask

  initial begin : watchdog
    repeat (WATCHDOG) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", WATCHDOG, 0);
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin : stim
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    chk(ready == 1'b1 && done == 1'b0, "R1 in reset", {30'd0, ready, done}, 2);
    rst_n = 1'b1;
    @(negedge clk);
    chk(ready == 1'b1 && done == 1'b0, "R1 after reset", {30'd0, ready, done}, 2);

    // R2 lone primary, with junk on ignored inputs (R8)
    for (int c = 0; c < 4; c++) begin
      run_pair(2'(c), 2'b10, 1'b0, 1'b0, 1'b0, 1'b0, "R2 solo");
      idle_check();
      run_pair(2'(c), 2'b10, 1'b0, 1'b1, 1'b1, 1'b0, "R8 flags ignored");
      idle_check();
    end
    // R3/R4/R5 table, issued back to back (R12)
    for (int p = 0; p < 3; p++)
      for (int s = 0; s < 3; s++)
        run_pair(2'(p), 2'(s), 1'b1, 1'b0, 1'b0, 1'b0,
                 p == 0 ? "R3 reg row" : (p == 1 ? "R4 rm row" : "R5 rmw row R12"));
    idle_check();
    run_pair(2'b10, 2'b01, 1'b1, 1'b0, 1'b0, 1'b0, "R5 rmw-first 4");
    run_pair(2'b01, 2'b10, 1'b1, 1'b0, 1'b0, 1'b0, "R4 rm-first 3");
    run_pair(2'b11, 2'b11, 1'b1, 1'b0, 1'b0, 1'b0, "R2 rsvd as reg");
    // R6 bank conflict
    run_pair(2'b00, 2'b00, 1'b1, 1'b1, 1'b0, 1'b0, "R6 bank reg/reg");
    run_pair(2'b10, 2'b00, 1'b1, 1'b1, 1'b0, 1'b0, "R6 bank no effect");
    run_pair(2'b01, 2'b01, 1'b1, 1'b1, 1'b0, 1'b0, "R6 bank no effect");
    // R7 stall
    run_pair(2'b00, 2'b00, 1'b1, 1'b0, 1'b1, 1'b0, "R7 agi");
    run_pair(2'b10, 2'b10, 1'b1, 1'b0, 1'b1, 1'b0, "R7 agi max");
    run_pair(2'b00, 2'b00, 1'b1, 1'b1, 1'b1, 1'b0, "R7 agi plus bank");
    // R11 issue pulses while busy
    run_pair(2'b10, 2'b10, 1'b1, 1'b0, 1'b0, 1'b1, "R11 busy issue ignored");
    run_pair(2'b00, 2'b01, 1'b1, 1'b0, 1'b1, 1'b1, "R11 busy issue ignored");
    idle_check();

    for (int i = 0; i < 300; i++) begin
      run_pair(2'($urandom_range(0, 3)), 2'($urandom_range(0, 3)),
               1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
               1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)), "R9 random");
      if ($urandom_range(0, 2) == 0) idle_check();
    end

    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

endmodule